// File: doc/BRIEF.md
# Lockable Controller Configuration Registers

This block holds the configuration and mode fields of a byte-oriented command interface of the kind used by disk controllers. The host loads fields through a small byte write port, selecting one of four register slots with an address. Every field is driven out in parallel to the rest of the controller. The block also drives three gated FIFO-use outputs. These let the data path ignore the FIFO disable bits while the FIFO itself is off.

The block has two reset inputs. A hardware reset returns everything to its defaults. A software reset returns the mode fields to their defaults, but the group of FIFO-related fields survives it while a lock bit is set. The lock bit changes in two steps. The host first writes a lock command byte, which carries the requested lock value, and nothing changes at that point. The new lock value is applied only when the host reads back the command's result byte. A reset of either kind that arrives between those two steps throws the request away.

Top module: `cfg_lock_regs`

## Requirements
- R1: Hardware reset sets `lock` to 0, sets every field output to 0, and makes `result_data` read 0x00.
- R2: Writes go to the slot chosen by `wr_addr`. Slot 0 holds bits [3:0] FIFO threshold and bit 4 FIFO enable. Slot 1 holds the 8-bit precompensation track. Slot 2 holds bit 0 motor-timer mode, bit 1 index-field omit, bit 2 implied seek, bit 3 extended track, bit 4 recalibrate limit, and bits [6:5] low-power mode. Slot 3 holds bit 0 FIFO write disable, bit 1 FIFO read disable, and bit 2 burst disable. The field outputs take the written value on the cycle after the write.
- R3: A lock command (`lock_cmd_wr`) takes the requested lock value from `wr_data[7]` and leaves `lock` unchanged. `lock` takes the requested value on the cycle after `result_rd` is pulsed while that request is pending.
- R4: While a lock request is pending, `result_data` reads the requested value in bit 4, with every other bit 0. With no request pending, it reads 0x00, and pulsing `result_rd` does not change `lock`.
- R5: A software or hardware reset that comes between a lock command and its result read discards the request. A later `result_rd` leaves `lock` unchanged.
- R6: A software reset while `lock` is 1 leaves the threshold, FIFO enable, precompensation track, write-disable, read-disable and burst-disable fields unchanged.
- R7: A software reset while `lock` is 0 clears those six FIFO fields to 0. This means the FIFO is off, FIFO writes and reads are allowed, and burst is enabled.
- R8: A software reset clears the motor-timer, index-omit, implied-seek, extended-track and recalibrate-limit bits, and sets low-power mode to 00. It leaves `lock` unchanged.
- R9: `fifo_wr_use`, `fifo_rd_use` and `fifo_burst_use` are 0 while FIFO enable is 0. While it is 1, each one is the inverse of its disable bit.
- R10: When both resets are asserted in the same cycle, the hardware reset wins: `lock` and every field become 0.
- R11: Writes and lock commands presented in a cycle where either reset is asserted are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst | input | 1 | Synchronous hardware reset, active high |
| sw_rst | input | 1 | Synchronous software reset, active high |
| wr_en | input | 1 | Register byte write strobe |
| wr_addr | input | 2 | Register slot select |
| wr_data | input | 8 | Write byte; bit 7 is the requested lock value for a lock command |
| lock_cmd_wr | input | 1 | Lock command byte written |
| result_rd | input | 1 | Lock result byte read by host |
| result_data | output | 8 | Lock result byte |
| lock | output | 1 | Committed lock bit |
| fifo_thr | output | 4 | FIFO threshold |
| fifo_en | output | 1 | FIFO enable |
| pretrk | output | 8 | Precompensation start track |
| fifo_wr_dis | output | 1 | FIFO write-disable bit |
| fifo_rd_dis | output | 1 | FIFO read-disable bit |
| burst_dis | output | 1 | Burst-disable bit |
| fifo_wr_use | output | 1 | Host writes go through FIFO |
| fifo_rd_use | output | 1 | Host reads go through FIFO |
| fifo_burst_use | output | 1 | Burst transfers in use |
| motor_tmr | output | 1 | Motor timer mode |
| idx_omit | output | 1 | Omit index field on format |
| impl_seek | output | 1 | Implied seek enable |
| ext_trk | output | 1 | Extended track range |
| recal_max | output | 1 | Long recalibrate limit |
| low_pwr | output | 2 | Low-power mode |

## Verification
The hardest state to reach from the ports is a pending lock request that a reset cuts off, followed by a result read that must then do nothing. Getting there takes a specific three-step sequence with a reset in the middle. Directed steps drive that sequence with both reset types and both lock values. Random stimulus also mixes lock commands, result reads and both resets at fairly high rates, so pending requests often meet resets and stray reads. Every cycle is compared with a reference state kept in the bench.

// File: rtl/cfg_lock_regs.sv
module cfg_lock_regs #(
  parameter int THR_W  = 4,
  parameter int PTRK_W = 8,
  parameter int LOCK_RES_BIT = 4
) (
  input  logic              clk,
  input  logic              hw_rst,
  input  logic              sw_rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              lock_cmd_wr,
  input  logic              result_rd,
  output logic [7:0]        result_data,
  output logic              lock,
  output logic [THR_W-1:0]  fifo_thr,
  output logic              fifo_en,
  output logic [PTRK_W-1:0] pretrk,
  output logic              fifo_wr_dis,
  output logic              fifo_rd_dis,
  output logic              burst_dis,
  output logic              fifo_wr_use,
  output logic              fifo_rd_use,
  output logic              fifo_burst_use,
  output logic              motor_tmr,
  output logic              idx_omit,
  output logic              impl_seek,
  output logic              ext_trk,
  output logic              recal_max,
  output logic [1:0]        low_pwr
);

  logic lock_pend, lock_req;

  assign result_data    = lock_pend ? (8'(lock_req) << LOCK_RES_BIT) : 8'h00;
  assign fifo_wr_use    = fifo_en & ~fifo_wr_dis;
  assign fifo_rd_use    = fifo_en & ~fifo_rd_dis;
  assign fifo_burst_use = fifo_en & ~burst_dis;

  always_ff @(posedge clk) begin
    if (hw_rst) begin
      lock <= 1'b0;  lock_pend <= 1'b0;  lock_req <= 1'b0;
      fifo_thr <= '0;  fifo_en <= 1'b0;  pretrk <= '0;
      fifo_wr_dis <= 1'b0;  fifo_rd_dis <= 1'b0;  burst_dis <= 1'b0;
      motor_tmr <= 1'b0;  idx_omit <= 1'b0;  impl_seek <= 1'b0;
      ext_trk <= 1'b0;  recal_max <= 1'b0;  low_pwr <= 2'b00;
    end else if (sw_rst) begin
      lock_pend <= 1'b0;
      motor_tmr <= 1'b0;  idx_omit <= 1'b0;  impl_seek <= 1'b0;
      ext_trk <= 1'b0;  recal_max <= 1'b0;  low_pwr <= 2'b00;
      if (!lock) begin
        fifo_thr <= '0;  fifo_en <= 1'b0;  pretrk <= '0;
        fifo_wr_dis <= 1'b0;  fifo_rd_dis <= 1'b0;  burst_dis <= 1'b0;
      end
    end else begin
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin fifo_thr <= wr_data[THR_W-1:0]; fifo_en <= wr_data[4]; end
          2'd1: pretrk <= wr_data[PTRK_W-1:0];
          2'd2: begin
            motor_tmr <= wr_data[0];  idx_omit <= wr_data[1];
            impl_seek <= wr_data[2];  ext_trk  <= wr_data[3];
            recal_max <= wr_data[4];  low_pwr  <= wr_data[6:5];
          end
          default: begin
            fifo_wr_dis <= wr_data[0];  fifo_rd_dis <= wr_data[1];
            burst_dis   <= wr_data[2];
          end
        endcase
      end
      if (result_rd && lock_pend) lock <= lock_req;
      if (lock_cmd_wr) begin
        lock_pend <= 1'b1;
        lock_req  <= wr_data[7];
      end else if (result_rd) begin
        lock_pend <= 1'b0;
      end
    end
  end

  a_r3_lock_only_on_read: assert property (@(posedge clk) disable iff (hw_rst)
    !(result_rd && lock_pend && !sw_rst) |=> $stable(lock));

  a_r5_reset_drops_request: assert property (@(posedge clk) disable iff (hw_rst)
    sw_rst |=> (result_data == 8'h00));

  a_r6_locked_fifo_kept: assert property (@(posedge clk) disable iff (hw_rst)
    (sw_rst && lock) |=> ($stable(fifo_thr) && $stable(fifo_en) && $stable(pretrk) &&
                          $stable(fifo_wr_dis) && $stable(fifo_rd_dis) && $stable(burst_dis)));

  a_r7_unlocked_fifo_clear: assert property (@(posedge clk) disable iff (hw_rst)
    (sw_rst && !lock) |=> (fifo_thr == '0 && !fifo_en && pretrk == '0 &&
                           !fifo_wr_dis && !fifo_rd_dis && !burst_dis));

  a_r8_mode_clear: assert property (@(posedge clk) disable iff (hw_rst)
    sw_rst |=> (!motor_tmr && !idx_omit && !impl_seek && !ext_trk && !recal_max &&
                low_pwr == 2'b00 && $stable(lock)));

endmodule

// File: tb/tb_cfg_lock_regs.sv
`timescale 1ns/1ps
module tb_cfg_lock_regs;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic hw_rst, sw_rst, wr_en, lock_cmd_wr, result_rd;
  logic [1:0] wr_addr;
  logic [7:0] wr_data, result_data, pretrk;
  logic lock, fifo_en, fifo_wr_dis, fifo_rd_dis, burst_dis;
  logic fifo_wr_use, fifo_rd_use, fifo_burst_use;
  logic motor_tmr, idx_omit, impl_seek, ext_trk, recal_max;
  logic [3:0] fifo_thr;
  logic [1:0] low_pwr;

  cfg_lock_regs dut (.*);

  int checks = 0, failures = 0;
  bit done = 0;

  logic e_lock, e_pend, e_req, e_fen, e_wd, e_rd, e_bd;
  logic [3:0] e_thr;
  logic [7:0] e_ptk;
  logic [6:0] e_mode;

  function automatic logic [7:0] exp_result(logic p, logic v);
    return p ? {3'b000, v, 4'b0000} : 8'h00;
  endfunction

  function automatic logic [34:0] exp_vec();
    return {e_lock, e_thr, e_fen, e_ptk, e_wd, e_rd, e_bd, e_mode,
            exp_result(e_pend, e_req), e_fen & ~e_wd, e_fen & ~e_rd, e_fen & ~e_bd};
  endfunction

  function automatic logic [34:0] act_vec();
    return {lock, fifo_thr, fifo_en, pretrk, fifo_wr_dis, fifo_rd_dis, burst_dis,
            low_pwr, recal_max, ext_trk, impl_seek, idx_omit, motor_tmr,
            result_data, fifo_wr_use, fifo_rd_use, fifo_burst_use};
  endfunction

  task automatic check(string tag);
    checks++;
    if (act_vec() !== exp_vec()) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act_vec(), exp_vec());
    end
  endtask

  task automatic model(logic h, logic s, logic we, logic [1:0] a, logic [7:0] d, logic c, logic r);
    if (h) begin
      e_lock = 0; e_pend = 0; e_req = 0; e_thr = 0; e_fen = 0; e_ptk = 0;
      e_wd = 0; e_rd = 0; e_bd = 0; e_mode = 0;
    end else if (s) begin
      e_pend = 0; e_mode = 0;
      if (!e_lock) begin e_thr = 0; e_fen = 0; e_ptk = 0; e_wd = 0; e_rd = 0; e_bd = 0; end
    end else begin
      if (we) case (a)
        2'd0: begin e_thr = d[3:0]; e_fen = d[4]; end
        2'd1: e_ptk = d;
        2'd2: e_mode = d[6:0];
        default: begin e_wd = d[0]; e_rd = d[1]; e_bd = d[2]; end
      endcase
      if (r && e_pend) e_lock = e_req;
      if (c) begin e_pend = 1; e_req = d[7]; end
      else if (r) e_pend = 0;
    end
  endtask

  task automatic cyc(logic h, logic s, logic we, logic [1:0] a, logic [7:0] d, logic c, logic r);
    hw_rst = h; sw_rst = s; wr_en = we; wr_addr = a; wr_data = d; lock_cmd_wr = c; result_rd = r;
    @(posedge clk);
    model(h, s, we, a, d, c, r);
    @(negedge clk);
    hw_rst = 0; sw_rst = 0; wr_en = 0; lock_cmd_wr = 0; result_rd = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d); cyc(0, 0, 1, a, d, 0, 0); endtask
  task automatic lock_cmd(logic v); cyc(0, 0, 0, 0, {v, 7'h00}, 1, 0); endtask
  task automatic res_rd(); cyc(0, 0, 0, 0, 8'h00, 0, 1); endtask
  task automatic swr(); cyc(0, 1, 0, 0, 8'h00, 0, 0); endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    hw_rst = 1; sw_rst = 0; wr_en = 0; wr_addr = 0; wr_data = 0; lock_cmd_wr = 0; result_rd = 0;
    @(negedge clk);
    cyc(1, 0, 0, 0, 8'h00, 0, 0);
    check("R1 hardware reset state");

    wr(2'd0, 8'h1A); wr(2'd1, 8'h5C); wr(2'd2, 8'h7F); wr(2'd3, 8'h05);
    check("R2 all slots written");

    lock_cmd(1);
    check("R3 lock unchanged after command byte");
    if (result_data !== 8'h10) begin
      failures++; $display("FAIL R4 result actual=%h expected=10", result_data);
    end
    checks++;
    res_rd();
    check("R3 lock committed on result read");
    if (lock !== 1'b1) begin failures++; $display("FAIL R3 lock actual=%b expected=1", lock); end
    checks++;
    res_rd();
    check("R4 stray result read with nothing pending");

    swr();
    check("R6 R8 locked software reset keeps FIFO fields, clears mode");

    lock_cmd(0); swr(); res_rd();
    check("R5 software reset discards pending unlock");
    if (lock !== 1'b1) begin failures++; $display("FAIL R5 lock actual=%b expected=1", lock); end
    checks++;

    lock_cmd(0); res_rd();
    wr(2'd2, 8'h2B);
    swr();
    check("R7 unlocked software reset clears FIFO fields");
    if (fifo_thr !== 4'h0 || pretrk !== 8'h00) begin
      failures++; $display("FAIL R7 thr=%h ptk=%h expected=0", fifo_thr, pretrk);
    end
    checks++;

    wr(2'd3, 8'h00); wr(2'd0, 8'h03);
    check("R9 FIFO off gates use outputs");
    wr(2'd0, 8'h13); wr(2'd3, 8'h01);
    check("R9 FIFO on, write disabled");

    lock_cmd(1); res_rd(); wr(2'd1, 8'hA5);
    cyc(1, 1, 1, 2'd1, 8'hFF, 1, 0);
    check("R10 hardware reset wins over software reset");

    lock_cmd(1); res_rd(); wr(2'd2, 8'h11);
    cyc(0, 1, 1, 2'd0, 8'h1F, 1, 0);
    check("R11 write and lock command ignored during reset");
    res_rd();
    check("R11 no pending request after reset cycle");

    lock_cmd(0); cyc(1, 0, 0, 0, 8'h00, 0, 0); res_rd();
    check("R5 hardware reset discards pending request");

    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      int unsigned r = $urandom();
      cyc((r[9:0] == 0), (r[14:11] == 0), r[15], r[17:16], r[25:18], (r[28:26] == 0), (r[31:29] == 0));
      check("R2 R3 R6 R7 R8 random sequence");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule